// File: doc/BRIEF.md
# Programmed-I/O Slave Register Sequencer

This block answers register reads and writes that a host issues over a shared 16-bit address/data bus with asynchronous handshake lines. When the host asserts its sync line, the block captures the word on the bus and checks whether it falls inside the device's address window. For that check, the I/O-page select must be low and bits 15:4 must equal a parameterised base. A match makes the block keep the four low bits as a register index. That index selects a location in the local register file, at file address 0x10 plus the index.

After an accepted address phase the host raises either its read strobe or its write strobe. A hard-wired sequencer then walks through states 1, 2 and 7. On a read it raises a data-in flag and fires a one-cycle data-available pulse in state 2. It then drives the captured file word onto the bus in state 7. On a write it raises a data-out flag, captures the bus word and fires a one-cycle write strobe to the register file in state 2. Both kinds of cycle assert the reply line in state 7. The reply stays up until the host releases sync.

A reply watchdog counts the cycles spent waiting for the reply. If the limit passes first, it raises a one-cycle lateness pulse. The default limit is 50 cycles, which is 10 us at a 200 ns clock.

Top module: `pio_slave_seq`

## Requirements
- R1: A cycle is accepted only if, in the clock cycle where the synchronised sync first reads asserted, `bus_page_n` is 0 and `bus_dal_i[15:4]` equals BASE[15:4] (default 0xF55). Otherwise `bus_active`, `bus_reply`, `data_avail` and `file_wr_stb` all stay 0 for the whole cycle.
- R2: On acceptance, `file_addr` becomes {1'b1, `bus_dal_i[3:0]`}. It holds that value until the cycle ends, even after the bus word changes.
- R3: An accepted cycle visits states 1, 2 and 7 in that order. After the read or write strobe is driven, the state-2 pulse is high after the third rising edge and `bus_reply` is high after the fourth.
- R4: On a read, `din_flag` is 1 and `dout_flag` is 0. `data_avail` is high for exactly one cycle, `file_wr_stb` never rises, and in state 7 `bus_dal_o` equals `file_rd_data` sampled in state 2, with `bus_dal_oe` = 1.
- R5: On a write, `dout_flag` is 1 and `din_flag` is 0. `file_wr_stb` is high for exactly one cycle with `file_wr_data` equal to the bus word of the data phase. `data_avail` and `bus_dal_oe` stay 0.
- R6: `bus_reply` stays high while sync is held. After sync is released it is still high after two rising edges and low after the third, with `bus_active` and both flags cleared.
- R7: If sync is released before a strobe arrives, the cycle returns to idle without any reply or pulse. A later strobe with sync released is ignored.
- R8: If state 1 or 2 lasts REPLY_LIMIT cycles, `reply_late` is high for exactly one cycle. Measured from sync assertion, that is after rising edge 2+REPLY_LIMIT+1 (53 by default).
- R9: While `rst_n` is 0 every output is 0, including when reset arrives in the middle of a reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (200 ns nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_dal_i | input | 16 | Address/data word received from the bus |
| bus_page_n | input | 1 | I/O-page select, active low |
| bus_sync_n | input | 1 | Host sync, active low, asynchronous |
| bus_din_n | input | 1 | Host read strobe, active low, asynchronous |
| bus_dout_n | input | 1 | Host write strobe, active low, asynchronous |
| file_rd_data | input | 16 | Register file word at `file_addr` |
| bus_dal_o | output | 16 | Read word for the bus drivers |
| bus_dal_oe | output | 1 | Bus driver enable |
| bus_reply | output | 1 | Reply to the host |
| file_addr | output | 5 | Register file address |
| file_wr_data | output | 16 | Word to write into the register file |
| file_wr_stb | output | 1 | One-cycle write strobe |
| data_avail | output | 1 | One-cycle read data-available pulse |
| din_flag | output | 1 | Read cycle in progress |
| dout_flag | output | 1 | Write cycle in progress |
| bus_active | output | 1 | Accepted cycle in progress |
| reply_late | output | 1 | One-cycle pulse: reply limit exceeded |

## Verification
Every host line passes a two-stage synchroniser, so each result falls due a fixed number of rising edges after the bench moves an input at a falling edge:
- `bus_active` and `file_addr` settle after edge 3 from sync.
- The state-2 pulse is due after edge 3 from the strobe, and the reply after edge 4.
- The reply drops after edge 3 from sync release.
- The lateness pulse is due after edge 53 from sync.

The bench moves inputs and samples outputs only at falling edges. It counts those edges to the due cycle and also checks the cycle just before it. That way both an early result and a late one show up as mismatches.

// File: rtl/pio_seq_pkg.sv
// Package: shared state encoding for the programmed-I/O slave sequencer.
// Assumes: the state numbers 1, 2 and 7 are visible to the checker.
package pio_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ONE   = 3'd1,
        ST_TWO   = 3'd2,
        ST_SEVEN = 3'd7
    } seq_state_e;
endpackage

// File: rtl/pio_sync.sv
// Module: multi-stage synchroniser for one asynchronous level.
// Assumes: input is a slow handshake level; reset value is deasserted (0).
module pio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop capture of the level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_chain
            // Shift the level through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pio_addr_dec.sv
// Module: device window decoder for the address phase.
// Assumes: page select active low; window is aligned to 2**IDXW words.
module pio_addr_dec #(
    parameter int          DW   = 16,
    parameter int          IDXW = 4,
    parameter logic [15:0] BASE = 16'hF550
) (
    input  logic [DW-1:0]   dal_i,
    input  logic            page_n,
    output logic            hit_o,
    output logic [IDXW-1:0] idx_o
);
    localparam logic [DW-1:0] BASE_W = DW'(BASE);

    // Compare block bits and qualify with the page select.
    always_comb begin
        hit_o = !page_n && (dal_i[DW-1:IDXW] == BASE_W[DW-1:IDXW]);
        idx_o = dal_i[IDXW-1:0];
    end
endmodule

// File: rtl/pio_reply_wdog.sv
// Module: reply watchdog; pulses once when pending lasts LIMIT cycles.
// Assumes: pending drops to 0 whenever the sequencer reaches reply or idle.
module pio_reply_wdog #(
    parameter int LIMIT = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic late_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Count pending cycles, saturate past the limit, pulse on reaching it.
    always_ff @(posedge clk) begin
        if (!rst_n || !pending_i) begin
            cnt_q  <= '0;
            late_o <= 1'b0;
        end else if (cnt_q == CW'(LIMIT - 1)) begin
            cnt_q  <= cnt_q + 1'b1;
            late_o <= 1'b1;
        end else begin
            late_o <= 1'b0;
            if (cnt_q < CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pio_slave_seq.sv
// Module: top of the programmed-I/O slave sequencer (states 1, 2, 7).
// Assumes: host keeps the address word on the bus for at least SYNC_STAGES+1
// cycles after asserting sync, and the data word until the reply.
module pio_slave_seq #(
    parameter int          DW          = 16,
    parameter int          IDXW        = 4,
    parameter logic [15:0] BASE        = 16'hF550,
    parameter int          SYNC_STAGES = 2,
    parameter int          REPLY_LIMIT = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     bus_dal_i,
    input  logic              bus_page_n,
    input  logic              bus_sync_n,
    input  logic              bus_din_n,
    input  logic              bus_dout_n,
    input  logic [DW-1:0]     file_rd_data,
    output logic [DW-1:0]     bus_dal_o,
    output logic              bus_dal_oe,
    output logic              bus_reply,
    output logic [IDXW:0]     file_addr,
    output logic [DW-1:0]     file_wr_data,
    output logic              file_wr_stb,
    output logic              data_avail,
    output logic              din_flag,
    output logic              dout_flag,
    output logic              bus_active,
    output logic              reply_late
);
    import pio_seq_pkg::*;

    seq_state_e      state_q;
    logic            sync_s, din_s, dout_s, sync_d;
    logic            sync_rise, addr_hit, pending;
    logic [IDXW-1:0] idx_dec, idx_q;
    logic [DW-1:0]   rd_q, wr_q;

    pio_sync #(.STAGES(SYNC_STAGES)) u_sync_sync (
        .clk(clk), .rst_n(rst_n), .async_i(!bus_sync_n), .sync_o(sync_s));
    pio_sync #(.STAGES(SYNC_STAGES)) u_sync_din (
        .clk(clk), .rst_n(rst_n), .async_i(!bus_din_n), .sync_o(din_s));
    pio_sync #(.STAGES(SYNC_STAGES)) u_sync_dout (
        .clk(clk), .rst_n(rst_n), .async_i(!bus_dout_n), .sync_o(dout_s));

    pio_addr_dec #(.DW(DW), .IDXW(IDXW), .BASE(BASE)) u_dec (
        .dal_i(bus_dal_i), .page_n(bus_page_n), .hit_o(addr_hit), .idx_o(idx_dec));

    // Delayed sync for edge detection of the address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_d <= 1'b0;
        else        sync_d <= sync_s;
    end

    assign sync_rise = sync_s && !sync_d;

    // Sequencer: idle -> 1 -> 2 -> 7 -> idle, abort on early sync release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            bus_active <= 1'b0;
            din_flag   <= 1'b0;
            dout_flag  <= 1'b0;
            idx_q      <= '0;
            rd_q       <= '0;
            wr_q       <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sync_rise && addr_hit) begin
                        state_q    <= ST_ONE;
                        bus_active <= 1'b1;
                        idx_q      <= idx_dec;
                    end
                end
                ST_ONE: begin
                    if (!sync_s) begin
                        state_q    <= ST_IDLE;
                        bus_active <= 1'b0;
                    end else if (din_s) begin
                        state_q  <= ST_TWO;
                        din_flag <= 1'b1;
                    end else if (dout_s) begin
                        state_q   <= ST_TWO;
                        dout_flag <= 1'b1;
                        wr_q      <= bus_dal_i;
                    end
                end
                ST_TWO: begin
                    if (!sync_s) begin
                        state_q    <= ST_IDLE;
                        bus_active <= 1'b0;
                        din_flag   <= 1'b0;
                        dout_flag  <= 1'b0;
                    end else begin
                        state_q <= ST_SEVEN;
                        if (din_flag) rd_q <= file_rd_data;
                    end
                end
                ST_SEVEN: begin
                    if (!sync_s) begin
                        state_q    <= ST_IDLE;
                        bus_active <= 1'b0;
                        din_flag   <= 1'b0;
                        dout_flag  <= 1'b0;
                        rd_q       <= '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode state into strobes, reply and driver enable.
    always_comb begin
        data_avail   = (state_q == ST_TWO) && din_flag;
        file_wr_stb  = (state_q == ST_TWO) && dout_flag;
        bus_reply    = (state_q == ST_SEVEN);
        bus_dal_oe   = (state_q == ST_SEVEN) && din_flag;
        bus_dal_o    = rd_q;
        file_wr_data = wr_q;
        file_addr    = {bus_active, idx_q};
        pending      = (state_q == ST_ONE) || (state_q == ST_TWO);
    end

    pio_reply_wdog #(.LIMIT(REPLY_LIMIT)) u_wdog (
        .clk(clk), .rst_n(rst_n), .pending_i(pending), .late_o(reply_late));
endmodule

// File: rtl/pio_slave_seq_chk.sv
// Module: property checker for pio_slave_seq, attached by bind.
// Assumes: observes the sequencer state and synchronised sync only.
module pio_slave_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] state_q,
    input logic       sync_s,
    input logic       addr_hit,
    input logic       bus_active,
    input logic       bus_reply,
    input logic       bus_dal_oe,
    input logic       data_avail,
    input logic       file_wr_stb,
    input logic       din_flag,
    input logic       dout_flag,
    input logic       reply_late
);
    // Acceptance only follows a decoded hit.
    assert_accept_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_active) |-> $past(addr_hit));

    // State 2 is always followed by 7 or an abort to idle.
    assert_two_then_seven_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == 3'd2) |=> (state_q == 3'd7 || state_q == 3'd0));

    // State 7 is only entered from state 2.
    assert_seven_from_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == 3'd7 && $past(state_q) != 3'd7) |-> $past(state_q) == 3'd2);

    // Read pulse only on read cycles; never together with write strobe.
    assert_avail_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_avail |-> (din_flag && !dout_flag && $onehot0({data_avail, file_wr_stb})));

    // Drivers only enabled on read cycles.
    assert_oe_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dal_oe |-> (din_flag && !dout_flag));

    // Reply held while sync remains asserted.
    assert_reply_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reply && sync_s) |=> bus_reply);

    // Reply never rises without a state-2 pulse just before.
    assert_reply_after_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_reply) |-> $past(data_avail || file_wr_stb));

    // Lateness indication is a single-cycle pulse.
    assert_late_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reply_late |=> !reply_late);
endmodule

bind pio_slave_seq pio_slave_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .sync_s(sync_s),
    .addr_hit(addr_hit), .bus_active(bus_active), .bus_reply(bus_reply),
    .bus_dal_oe(bus_dal_oe), .data_avail(data_avail), .file_wr_stb(file_wr_stb),
    .din_flag(din_flag), .dout_flag(dout_flag), .reply_late(reply_late));

// File: tb/pio_slave_seq_tb.sv
module pio_slave_seq_tb;
    localparam int CLK_PERIOD = 200;
    localparam int WD_CYCLES  = 20000;
    localparam int NVEC       = 7;

    // {is_read, page_n, accept, address, write data}
    localparam logic [34:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b1, 16'hF552, 16'h0000},
        {1'b0, 1'b0, 1'b1, 16'hF554, 16'h1234},
        {1'b1, 1'b0, 1'b1, 16'hF55A, 16'h0000},
        {1'b0, 1'b0, 1'b1, 16'hF550, 16'hFFFF},
        {1'b1, 1'b0, 1'b0, 16'hF562, 16'h0000},
        {1'b0, 1'b1, 1'b0, 16'hF556, 16'hBEEF},
        {1'b1, 1'b0, 1'b1, 16'hF55F, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_dal_i = '0;
    logic        bus_page_n = 1'b1, bus_sync_n = 1'b1, bus_din_n = 1'b1, bus_dout_n = 1'b1;
    logic [15:0] file_rd_data, bus_dal_o, file_wr_data;
    logic [4:0]  file_addr;
    logic        bus_dal_oe, bus_reply, file_wr_stb, data_avail;
    logic        din_flag, dout_flag, bus_active, reply_late;
    int          n_cmp = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Register file model: content derived from the address.
    assign file_rd_data = {8'hA5, 3'b000, file_addr};

    pio_slave_seq u_dut (
        .clk(clk), .rst_n(rst_n), .bus_dal_i(bus_dal_i), .bus_page_n(bus_page_n),
        .bus_sync_n(bus_sync_n), .bus_din_n(bus_din_n), .bus_dout_n(bus_dout_n),
        .file_rd_data(file_rd_data), .bus_dal_o(bus_dal_o), .bus_dal_oe(bus_dal_oe),
        .bus_reply(bus_reply), .file_addr(file_addr), .file_wr_data(file_wr_data),
        .file_wr_stb(file_wr_stb), .data_avail(data_avail), .din_flag(din_flag),
        .dout_flag(dout_flag), .bus_active(bus_active), .reply_late(reply_late));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // One host cycle; all timing counted in falling edges from the drive.
    task automatic host_cycle(input logic rd, input logic pg, input logic ok,
                              input logic [15:0] addr, input logic [15:0] wd);
        logic [15:0] exp_rd;
        exp_rd = {8'hA5, 3'b000, 1'b1, addr[3:0]};
        @(negedge clk);
        bus_dal_i = addr; bus_page_n = pg; bus_sync_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 accept", {31'd0, bus_active}, {31'd0, ok});
        if (ok) chk("R2 file_addr", {27'd0, file_addr}, {27'd0, 1'b1, addr[3:0]});
        bus_dal_i = rd ? 16'h0000 : wd;
        if (rd) bus_din_n = 1'b0; else bus_dout_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3 no early pulse", {30'd0, data_avail, file_wr_stb}, 32'd0);
        @(negedge clk);
        chk("R3 state-2 pulse", {30'd0, data_avail, file_wr_stb},
            {30'd0, ok && rd, ok && !rd});
        chk("R3 no early reply", {31'd0, bus_reply}, 32'd0);
        @(negedge clk);
        chk("R3 reply", {31'd0, bus_reply}, {31'd0, ok});
        chk("R4/R5 single pulse", {30'd0, data_avail, file_wr_stb}, 32'd0);
        if (ok && rd) begin
            chk("R4 read flags", {30'd0, din_flag, dout_flag}, 32'd2);
            chk("R4 read data", {16'd0, bus_dal_o}, {16'd0, exp_rd});
            chk("R4 drive enable", {31'd0, bus_dal_oe}, 32'd1);
            chk("R2 addr held", {27'd0, file_addr}, {27'd0, 1'b1, addr[3:0]});
        end
        if (ok && !rd) begin
            chk("R5 write flags", {30'd0, din_flag, dout_flag}, 32'd1);
            chk("R5 write data", {16'd0, file_wr_data}, {16'd0, wd});
            chk("R5 no drive", {31'd0, bus_dal_oe}, 32'd0);
        end
        if (!ok) chk("R1 ignored", {29'd0, bus_reply, din_flag, dout_flag}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R6 reply held", {31'd0, bus_reply}, {31'd0, ok});
        bus_sync_n = 1'b1; bus_din_n = 1'b1; bus_dout_n = 1'b1; bus_page_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 reply before release seen", {31'd0, bus_reply}, {31'd0, ok});
        @(negedge clk);
        chk("R6 idle", {28'd0, bus_reply, bus_active, din_flag, dout_flag}, 32'd0);
        repeat (2) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R9 reset outputs", {12'd0, bus_reply, bus_dal_oe, data_avail, file_wr_stb,
            bus_active, din_flag, dout_flag, reply_late, bus_dal_o},
            32'd0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NVEC; i++)
            host_cycle(VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:16], VEC[i][15:0]);

        // R7: early sync release aborts; later strobe ignored.
        @(negedge clk);
        bus_dal_i = 16'hF558; bus_page_n = 1'b0; bus_sync_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 accepted", {31'd0, bus_active}, 32'd1);
        bus_sync_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 aborted", {31'd0, bus_active}, 32'd0);
        bus_din_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7 no reply", {29'd0, bus_reply, data_avail, din_flag}, 32'd0);
        bus_din_n = 1'b1; bus_page_n = 1'b1;
        repeat (3) @(negedge clk);

        // R8: no strobe; late pulse exactly after edge 53.
        @(negedge clk);
        bus_dal_i = 16'hF552; bus_page_n = 1'b0; bus_sync_n = 1'b0;
        repeat (52) @(negedge clk);
        chk("R8 not yet late", {31'd0, reply_late}, 32'd0);
        @(negedge clk);
        chk("R8 late pulse", {31'd0, reply_late}, 32'd1);
        @(negedge clk);
        chk("R8 pulse ends", {31'd0, reply_late}, 32'd0);
        bus_sync_n = 1'b1; bus_page_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 back idle", {30'd0, bus_active, bus_reply}, 32'd0);

        // R9: reset during reply.
        @(negedge clk);
        bus_dal_i = 16'hF554; bus_page_n = 1'b0; bus_sync_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_din_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 reply before reset", {31'd0, bus_reply}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset mid-reply", {27'd0, bus_reply, bus_dal_oe, bus_active, din_flag,
            reply_late}, 32'd0);
        bus_sync_n = 1'b1; bus_din_n = 1'b1; bus_page_n = 1'b1;
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);

        summary();
        $finish;
    end
endmodule